// File: doc/BRIEF.md
# Programmable Sample Rate Strobe Generator

This block turns a single master clock into three streams of one-cycle sample strobes. The modem converter strobe and the handset converter strobe each come from their own fractional phase accumulator. The monitor speaker strobe is copied from one of those two, chosen by a configuration bit. Both accumulators take their rate from a 16-bit code. The handset code always counts in 1 Hz steps. The modem code counts in 1 Hz, 8/7 Hz or 10/7 Hz steps, chosen by a 2-bit step-size field.

Every rate is scaled by seven, so that all three step sizes become whole-number increments: 7, 8 or 10 per code unit. Each accumulator adds its increment on every clock. When the sum reaches seven times the master clock frequency in hertz, the accumulator subtracts that modulus and emits a strobe. The long-run strobe rate therefore equals the programmed rate in hertz, with no drift. Software sets the rates through a simple synchronous register bus with a combinational read port.

Top module: `rate_strobe_gen`

## Requirements
- R1: After a synchronous active-low reset, the modem code reads 0x1C20, the handset code reads 0x1F40 and the configuration reads 0x0000. No strobe is active during or immediately after reset.
- R2: A write with `bus_sel` and `bus_wr` high updates a register at the next clock edge. The modem code is at address 0x206, the handset code at 0x207 and the configuration at 0x20A. A read with `bus_sel` high and `bus_wr` low returns the addressed register in the same cycle. In the configuration register, bits [1:0] hold the step size and bit 8 holds the monitor source; all other bits read 0. Writes to any other address change nothing, and reads from them return 0.
- R3: Each accumulator holds a value below M = 7 × CLK_HZ. On each clock it adds its increment; if the sum is at least M, it stores the sum minus M, otherwise it stores the sum.
- R4: The modem increment is 7 × code for step size 00, 8 × code for 01 and 10 × code for 10.
- R5: The reserved step size 11 gives the same increment as 00.
- R6: The handset increment is always 7 × code, whatever the step size.
- R7: Monitor source 0 makes `mon_stb` equal `mdm_stb`; monitor source 1 makes it equal `hs_stb`. Changing the source takes effect in the cycle after the write edge.
- R8: Over any window of N clocks, the number of strobes on a channel is within one of N × increment / M.
- R9: A strobe is high for exactly the one cycle that follows the clock edge at which its accumulator wrapped.
- R10: A rate or step-size write changes the increment from the next clock edge onward. It keeps the accumulator's phase: nothing is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, CLK_HZ hertz |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (0 when no read is in progress) |
| mdm_stb | output | 1 | Modem converter sample strobe |
| hs_stb | output | 1 | Handset converter sample strobe |
| mon_stb | output | 1 | Monitor speaker sample strobe |

## Verification
The bench programs each step size, including the reserved value, and toggles the monitor source, because these are the cases a wrong multiplier or a swapped mux would betray. In every such case it compares the strobe counts over a fixed window against the programmed rate. A wrong multiplier shifts the modem count by a ratio of 8/7 or 10/7. A swapped monitor mux makes the monitor count follow the other channel. A cycle-accurate model then checks the exact strobe timing across rate changes. A design that cleared its phase on a write, or applied the new increment one edge late, would drift off that model. The bench also writes to an unmapped address and sets configuration bits that have no field, then reads back to confirm that neither stuck.

// File: rtl/srg_pkg.sv
// Shared constants and types for the sample rate strobe generator.
// Assumes a 10-bit register address space and 16-bit rate codes.
package srg_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 10;
    localparam int MULT_W = 4;
    localparam int INC_W  = DATA_W + MULT_W;
    localparam int N_CH   = 2;
    localparam int CH_MDM = 0;
    localparam int CH_HS  = 1;

    // Common denominator that turns 8/7 and 10/7 step sizes into integers
    localparam int RATE_DEN = 7;

    localparam logic [ADDR_W-1:0] A_MDM_RATE = 10'h206;
    localparam logic [ADDR_W-1:0] A_HS_RATE  = 10'h207;
    localparam logic [ADDR_W-1:0] A_RATE_CFG = 10'h20A;

    localparam logic [DATA_W-1:0] MDM_RATE_RST = 16'h1C20;
    localparam logic [DATA_W-1:0] HS_RATE_RST  = 16'h1F40;

    localparam int CFG_MODE_LSB = 0;
    localparam int CFG_MON_BIT  = 8;

    typedef enum logic [1:0] {
        LSB_1HZ   = 2'b00,
        LSB_8_7   = 2'b01,
        LSB_10_7  = 2'b10,
        LSB_RSVD  = 2'b11
    } lsb_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] mdm_code;
        logic [DATA_W-1:0] hs_code;
        lsb_mode_e         mode;
        logic              mon_hs;
    } rate_cfg_t;

    // Increment multiplier per code unit, in units of 1/RATE_DEN Hz
    function automatic logic [MULT_W-1:0] lsb_mult(input lsb_mode_e m);
        case (m)
            LSB_8_7:  return MULT_W'(8);
            LSB_10_7: return MULT_W'(10);
            default:  return MULT_W'(RATE_DEN);
        endcase
    endfunction

endpackage

// File: rtl/srg_regs.sv
// Register file for the strobe generator: modem code, handset code and
// configuration (step size, monitor source). Assumes single-cycle
// synchronous writes and a combinational read port.
module srg_regs
    import srg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output rate_cfg_t         cfg_o
);

    logic [DATA_W-1:0] mdm_q;
    logic [DATA_W-1:0] hs_q;
    lsb_mode_e         mode_q;
    logic              mon_q;
    logic              wr_en;
    logic              rd_en;

    // Decode access type
    always_comb begin
        wr_en = bus_sel && bus_wr;
        rd_en = bus_sel && !bus_wr;
    end

    // Capture writes to mapped registers; other addresses are ignored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdm_q  <= MDM_RATE_RST;
            hs_q   <= HS_RATE_RST;
            mode_q <= LSB_1HZ;
            mon_q  <= 1'b0;
        end else if (wr_en) begin
            case (bus_addr)
                A_MDM_RATE: mdm_q <= bus_wdata;
                A_HS_RATE:  hs_q  <= bus_wdata;
                A_RATE_CFG: begin
                    mode_q <= lsb_mode_e'(bus_wdata[CFG_MODE_LSB +: 2]);
                    mon_q  <= bus_wdata[CFG_MON_BIT];
                end
                default: ;
            endcase
        end
    end

    // Combinational read mux; zero when idle or unmapped
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                A_MDM_RATE: bus_rdata = mdm_q;
                A_HS_RATE:  bus_rdata = hs_q;
                A_RATE_CFG: begin
                    bus_rdata[CFG_MODE_LSB +: 2] = mode_q;
                    bus_rdata[CFG_MON_BIT]       = mon_q;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    // Pack the live configuration
    always_comb begin
        cfg_o.mdm_code = mdm_q;
        cfg_o.hs_code  = hs_q;
        cfg_o.mode     = mode_q;
        cfg_o.mon_hs   = mon_q;
    end

endmodule

// File: rtl/srg_inc_calc.sv
// Turns rate codes into per-clock accumulator increments, scaled by
// RATE_DEN so that every step size is an integer multiple of the code.
// Assumes the reserved step size maps to 1 Hz steps.
module srg_inc_calc
    import srg_pkg::*;
(
    input  rate_cfg_t                    cfg_i,
    output logic [N_CH-1:0][INC_W-1:0]   inc_o
);

    // Scale each channel's code by its step multiplier
    always_comb begin
        inc_o[CH_MDM] = INC_W'(cfg_i.mdm_code) * INC_W'(lsb_mult(cfg_i.mode));
        inc_o[CH_HS]  = INC_W'(cfg_i.hs_code)  * INC_W'(RATE_DEN);
    end

endmodule

// File: rtl/srg_phase_acc.sv
// Fractional phase accumulator: adds inc_i each clock, wraps modulo
// MODULUS and flags each wrap with a registered one-cycle strobe.
// Assumes inc_i < MODULUS so the sum fits in ACC_W+1 bits.
module srg_phase_acc #(
    parameter longint MODULUS = 118540800,
    parameter int     ACC_W   = 27,
    parameter int     INC_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             strobe_o
);

    localparam logic [ACC_W:0] MOD_V = (ACC_W+1)'(MODULUS);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             wrap;

    // Next phase and wrap detection
    always_comb begin
        sum  = {1'b0, acc_q} + (ACC_W+1)'(inc_i);
        wrap = (sum >= MOD_V);
    end

    // Update phase and strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            strobe_o <= 1'b0;
        end else begin
            acc_q    <= wrap ? ACC_W'(sum - MOD_V) : sum[ACC_W-1:0];
            strobe_o <= wrap;
        end
    end

    assign acc_o = acc_q;

endmodule

// File: rtl/rate_strobe_gen.sv
// Top of the sample rate strobe generator: register file, increment
// scaling, one phase accumulator per channel and the monitor source mux.
// Assumes CLK_HZ is the master clock frequency in hertz and that every
// programmed rate lies below it.
module rate_strobe_gen
    import srg_pkg::*;
#(
    parameter int CLK_HZ = 16934400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mdm_stb,
    output logic              hs_stb,
    output logic              mon_stb
);

    localparam longint MODULUS = longint'(CLK_HZ) * RATE_DEN;
    localparam int     ACC_W   = $clog2(MODULUS);

    rate_cfg_t                  cfg;
    logic [N_CH-1:0][INC_W-1:0] inc;
    logic [N_CH-1:0][ACC_W-1:0] acc;
    logic [N_CH-1:0]            stb;

    srg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cfg_o     (cfg)
    );

    srg_inc_calc u_inc (
        .cfg_i (cfg),
        .inc_o (inc)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        srg_phase_acc #(
            .MODULUS (MODULUS),
            .ACC_W   (ACC_W),
            .INC_W   (INC_W)
        ) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_i    (inc[ch]),
            .acc_o    (acc[ch]),
            .strobe_o (stb[ch])
        );
    end

    // Route channel strobes and pick the monitor source
    always_comb begin
        mdm_stb = stb[CH_MDM];
        hs_stb  = stb[CH_HS];
        mon_stb = cfg.mon_hs ? stb[CH_HS] : stb[CH_MDM];
    end

endmodule

// File: rtl/srg_chk.sv
// Assertion checker for rate_strobe_gen, attached with bind below.
// Assumes the accumulator phases and register codes of the top are visible.
module srg_chk
    import srg_pkg::*;
#(
    parameter int     ACC_W   = 27,
    parameter longint MODULUS = 118540800
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] mdm_code,
    input logic [DATA_W-1:0] hs_code,
    input logic [ACC_W-1:0]  acc_mdm,
    input logic [ACC_W-1:0]  acc_hs,
    input logic              stb_mdm,
    input logic              stb_hs,
    input logic              stb_mon
);

    localparam logic [ACC_W-1:0] MOD_L = ACC_W'(MODULUS);

    // R1
    reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mdm_code == MDM_RATE_RST && hs_code == HS_RATE_RST && !stb_mdm && !stb_hs));

    // R2
    mdm_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == A_MDM_RATE) |=> (mdm_code == $past(bus_wdata)));

    // R2
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(mdm_code) && $stable(hs_code)));

    // R3
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mdm < MOD_L) && (acc_hs < MOD_L));

    // R9
    strobe_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_mdm |-> (acc_mdm < $past(acc_mdm)));

    // R9
    no_strobe_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb_hs |-> (acc_hs >= $past(acc_hs)));

    // R7
    mon_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_mon |-> (stb_mdm || stb_hs));

endmodule

bind rate_strobe_gen srg_chk #(
    .ACC_W   (ACC_W),
    .MODULUS (MODULUS)
) u_srg_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .mdm_code  (cfg.mdm_code),
    .hs_code   (cfg.hs_code),
    .acc_mdm   (acc[0]),
    .acc_hs    (acc[1]),
    .stb_mdm   (stb[0]),
    .stb_hs    (stb[1]),
    .stb_mon   (mon_stb)
);

// File: tb/test_rate_strobe_gen.sv
// Self-checking bench: behavioural reference model compared on every clock,
// plus strobe-count windows and register read-back checks.
module test_rate_strobe_gen;

    localparam int     CLK_HZ = 96000;
    localparam longint MODV   = 7 * CLK_HZ;
    localparam int     WIN    = 12000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        mdm_stb, hs_stb, mon_stb;

    int n_chk = 0;
    int n_fail = 0;
    int mism = 0;
    bit done = 0;

    // Reference model state
    longint      m_acc_m, m_acc_h;
    logic [15:0] r_mdm, r_hs, r_cfg;
    bit          exp_m, exp_h, exp_mon;

    always #10 clk = ~clk;

    rate_strobe_gen #(.CLK_HZ(CLK_HZ)) i_rate_strobe_gen (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdm_stb(mdm_stb), .hs_stb(hs_stb), .mon_stb(mon_stb)
    );

    function automatic longint step_mult(input logic [1:0] md);
        case (md)
            2'b01:   return 8;
            2'b10:   return 10;
            default: return 7;
        endcase
    endfunction

    // Reference model: advance phases, then apply any write
    always @(posedge clk) begin
        longint s;
        if (!rst_n) begin
            m_acc_m = 0; m_acc_h = 0; exp_m = 0; exp_h = 0;
            r_mdm = 16'h1C20; r_hs = 16'h1F40; r_cfg = 16'h0000;
        end else begin
            s = m_acc_m + longint'(r_mdm) * step_mult(r_cfg[1:0]);
            exp_m = (s >= MODV);
            m_acc_m = exp_m ? s - MODV : s;
            s = m_acc_h + longint'(r_hs) * 7;
            exp_h = (s >= MODV);
            m_acc_h = exp_h ? s - MODV : s;
            if (bus_sel && bus_wr) begin
                if (bus_addr == 10'h206) r_mdm = bus_wdata;
                else if (bus_addr == 10'h207) r_hs = bus_wdata;
                else if (bus_addr == 10'h20A) r_cfg = bus_wdata & 16'h0103;
            end
        end
        exp_mon = r_cfg[8] ? exp_h : exp_m;
    end

    // Compare design strobes against the model every clock
    always @(negedge clk) begin
        if (rst_n && (mdm_stb !== exp_m || hs_stb !== exp_h || mon_stb !== exp_mon))
            mism++;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    // Count strobes over WIN clocks and check each within one of expectation
    task automatic run_window(input string tag, input longint inc_m, input longint inc_h, input bit mon_hs);
        longint cm = 0, ch = 0, cn = 0, em, eh, en;
        int m0 = mism;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (mdm_stb) cm++;
            if (hs_stb) ch++;
            if (mon_stb) cn++;
        end
        em = WIN * inc_m / MODV;
        eh = WIN * inc_h / MODV;
        en = mon_hs ? eh : em;
        check(cm >= em - 1 && cm <= em + 1, {tag, " R8 modem count"}, cm, em);
        check(ch >= eh - 1 && ch <= eh + 1, {tag, " R6 R8 handset count"}, ch, eh);
        check(cn >= en - 1 && cn <= en + 1, {tag, " R7 monitor count"}, cn, en);
        check(mism == m0, {tag, " R3 R9 R10 cycle model mismatches"}, mism - m0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        report();
    end

    initial begin
        logic [15:0] d;
        repeat (5) @(negedge clk);
        check(mdm_stb == 0 && hs_stb == 0 && mon_stb == 0, "R1 strobes low in reset", mdm_stb, 0);
        rst_n = 1;
        bus_read(10'h206, d); check(d == 16'h1C20, "R1 modem code reset", d, 16'h1C20);
        bus_read(10'h207, d); check(d == 16'h1F40, "R1 handset code reset", d, 16'h1F40);
        bus_read(10'h20A, d); check(d == 16'h0000, "R1 config reset", d, 0);

        // Defaults: 7200 Hz modem, 8000 Hz handset, monitor on modem
        run_window("default R4", 7200 * 7, 8000 * 7, 0);

        // Step 8/7, monitor on handset
        bus_write(10'h206, 16'd42000);
        bus_write(10'h207, 16'd5400);
        bus_write(10'h20A, 16'h0101);
        bus_read(10'h20A, d); check(d == 16'h0101, "R2 config read-back", d, 16'h0101);
        run_window("step01 R4", 42000 * 8, 5400 * 7, 1);

        // Step 10/7, monitor back on modem
        bus_write(10'h20A, 16'h0002);
        bus_write(10'h206, 16'd3780);
        bus_write(10'h207, 16'd8000);
        run_window("step10 R4", 3780 * 10, 8000 * 7, 0);

        // Reserved step with stray config bits set
        bus_write(10'h20A, 16'h8003);
        bus_read(10'h20A, d); check(d == 16'h0003, "R2 unused config bits read 0", d, 16'h0003);
        bus_write(10'h206, 16'd48000);
        run_window("step11 R5", 48000 * 7, 8000 * 7, 0);

        // Unmapped address: write ignored, read gives 0
        bus_write(10'h208, 16'hFFFF);
        bus_read(10'h208, d); check(d == 16'h0000, "R2 unmapped read", d, 0);
        bus_read(10'h206, d); check(d == 16'd48000, "R2 modem code untouched", d, 48000);
        bus_read(10'h207, d); check(d == 16'd8000, "R2 handset code untouched", d, 8000);
        bus_read(10'h20A, d); check(d == 16'h0003, "R2 config untouched", d, 3);
        check(mism == 0, "R10 total model mismatches", mism, 0);
        report();
    end

endmodule